// File: doc/BRIEF.md
# Comma-Based Lane Synchronization Tracker

This block decides whether a serial receive lane is in lock. It sits after a word aligner and an 8b/10b decoder and sees one 10-bit code group per qualified cycle. For each group it is told whether the group is a clean comma (K28.5) and whether the group is bad, meaning an invalid code or a disparity error. It produces a single lock flag and brings out its running error tally for debug.

Lock is gained by counting clean commas. Lock is lost through an error tally that leaks: each bad group adds one, and each unbroken run of good groups takes one away. A single error therefore does not drop the link. The tally has to climb to the loss limit before lock goes away. After a loss the block goes back to counting commas without any outside help. The comma target, the loss limit and the run length that buys back one error are all parameters. Their defaults are 4, 17 and 16.

Top module: `lane_sync_fsm`

## Requirements
- R1: After reset, `sync_ok` is 0 and `err_count` is 0.
- R2: While out of lock, `sync_ok` goes to 1 in the cycle after the ACQ_COMMAS-th valid comma group (default 4) is accepted. Good groups that are not commas neither add to nor clear the comma count.
- R3: While out of lock, a valid group with `cg_error` high clears the comma count. This holds even when `cg_comma` is also high, because the error flag takes priority.
- R4: While in lock, each valid erroneous group adds exactly one to `err_count` and restarts the good-group run.
- R5: While in lock, every HEAL_RUN (default 16) consecutive valid good groups take one away from `err_count`. The count never goes below 0.
- R6: While in lock, the valid erroneous group that brings the tally to LOSS_ERRS (default 17) makes `sync_ok` 0 and `err_count` 0 in the next cycle. After that, a fresh set of ACQ_COMMAS commas is needed to regain lock.
- R7: Cycles with `cg_valid` low change neither the lock state nor any counter, whatever `cg_comma` and `cg_error` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cg_valid | input | 1 | A code group is presented in this cycle |
| cg_comma | input | 1 | The presented group is a clean K28.5 comma |
| cg_error | input | 1 | The presented group has a code or disparity error |
| sync_ok | output | 1 | Lane is in lock |
| err_count | output | $clog2(LOSS_ERRS+1) | Current leaky error tally |

## Verification
The bound checker watches several rules on every cycle. An idle cycle leaves the lock flag and tally unchanged. The tally stays below the loss limit and is zero whenever the lane is out of lock. Lock only rises right after the comma target is met, and it always falls after a loss event. Each error steps the tally up by one, and each completed good run steps it down by one. Other rules depend on whole sequences of groups, so only the directed scenarios can show them: a bad group in the middle of acquisition restarts the comma count, a good run that an error breaks earns nothing, the floor at zero holds, and a full reacquisition is needed after a loss.

// File: rtl/lsync_pkg.sv
package lsync_pkg;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } lsync_state_e;

  // Comma count after one valid group while hunting.
  function automatic int unsigned acq_step(int unsigned cnt, logic comma, logic err);
    if (err)        return 0;
    else if (comma) return cnt + 1;
    else            return cnt;
  endfunction

  // Error tally after a completed good run; floors at zero.
  function automatic int unsigned leak_dec(int unsigned e);
    return (e == 0) ? 0 : e - 1;
  endfunction

  // Lock state transition.
  function automatic lsync_state_e state_next(lsync_state_e cur, logic acq_done, logic loss_hit);
    case (cur)
      ST_HUNT: return acq_done ? ST_LOCK : ST_HUNT;
      default: return loss_hit ? ST_HUNT : ST_LOCK;
    endcase
  endfunction

endpackage

// File: rtl/lsync_acq.sv
module lsync_acq #(
  parameter int ACQ_COMMAS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hunt,
  input  logic cg_valid,
  input  logic cg_comma,
  input  logic cg_error,
  output logic acq_done
);
  import lsync_pkg::*;

  localparam int CW = $clog2(ACQ_COMMAS + 1);

  logic [CW-1:0] cnt_q;

  assign acq_done = hunt & cg_valid & ~cg_error & cg_comma &
                    (cnt_q == CW'(ACQ_COMMAS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!hunt || acq_done)
      cnt_q <= '0;
    else if (cg_valid)
      cnt_q <= CW'(acq_step(int'(cnt_q), cg_comma, cg_error));
  end

endmodule

// File: rtl/lsync_err_leak.sv
module lsync_err_leak #(
  parameter int LOSS_ERRS = 17,
  parameter int HEAL_RUN  = 16,
  localparam int EW = $clog2(LOSS_ERRS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          locked,
  input  logic          cg_valid,
  input  logic          cg_error,
  output logic          loss_hit,
  output logic          heal_tick,
  output logic [EW-1:0] err_cnt
);
  import lsync_pkg::*;

  localparam int GW = $clog2(HEAL_RUN + 1);

  logic [EW-1:0] err_q;
  logic [GW-1:0] good_q;

  assign loss_hit  = locked & cg_valid &  cg_error & (err_q  == EW'(LOSS_ERRS - 1));
  assign heal_tick = locked & cg_valid & ~cg_error & (good_q == GW'(HEAL_RUN - 1));
  assign err_cnt   = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= '0;
      good_q <= '0;
    end else if (!locked || loss_hit) begin
      err_q  <= '0;
      good_q <= '0;
    end else if (cg_valid) begin
      if (cg_error) begin
        good_q <= '0;
        err_q  <= err_q + EW'(1);
      end else if (heal_tick) begin
        good_q <= '0;
        err_q  <= EW'(leak_dec(int'(err_q)));
      end else begin
        good_q <= good_q + GW'(1);
      end
    end
  end

endmodule

// File: rtl/lane_sync_fsm.sv
module lane_sync_fsm #(
  parameter int ACQ_COMMAS = 4,
  parameter int LOSS_ERRS  = 17,
  parameter int HEAL_RUN   = 16,
  localparam int EW = $clog2(LOSS_ERRS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cg_valid,
  input  logic          cg_comma,
  input  logic          cg_error,
  output logic          sync_ok,
  output logic [EW-1:0] err_count
);
  import lsync_pkg::*;

  lsync_state_e state_q;
  logic acq_done;
  logic loss_hit;
  logic heal_tick;
  logic hunt;
  logic locked;

  assign hunt   = (state_q == ST_HUNT);
  assign locked = (state_q == ST_LOCK);

  lsync_acq #(.ACQ_COMMAS(ACQ_COMMAS)) u_acq (
    .clk      (clk),
    .rst_n    (rst_n),
    .hunt     (hunt),
    .cg_valid (cg_valid),
    .cg_comma (cg_comma),
    .cg_error (cg_error),
    .acq_done (acq_done)
  );

  lsync_err_leak #(.LOSS_ERRS(LOSS_ERRS), .HEAL_RUN(HEAL_RUN)) u_leak (
    .clk       (clk),
    .rst_n     (rst_n),
    .locked    (locked),
    .cg_valid  (cg_valid),
    .cg_error  (cg_error),
    .loss_hit  (loss_hit),
    .heal_tick (heal_tick),
    .err_cnt   (err_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_HUNT;
    else        state_q <= state_next(state_q, acq_done, loss_hit);
  end

  assign sync_ok = locked;

endmodule

// File: rtl/lane_sync_fsm_chk.sv
module lane_sync_fsm_chk #(
  parameter int ACQ_COMMAS = 4,
  parameter int LOSS_ERRS  = 17,
  parameter int HEAL_RUN   = 16,
  localparam int EW = $clog2(LOSS_ERRS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cg_valid,
  input logic          cg_error,
  input logic          sync_ok,
  input logic [EW-1:0] err_count,
  input logic          acq_done,
  input logic          loss_hit,
  input logic          heal_tick
);

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !cg_valid |=> ($stable(sync_ok) && $stable(err_count))); // R7

  AST_TALLY_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    err_count < EW'(LOSS_ERRS)); // R6

  AST_UNLOCKED_TALLY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_ok |-> (err_count == '0)); // R1

  AST_LOCK_NEEDS_COMMAS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_ok) |-> $past(acq_done)); // R2

  AST_LOSS_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    loss_hit |=> (!sync_ok && err_count == '0)); // R6

  AST_ERROR_STEPS_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_ok && cg_valid && cg_error && !loss_hit) |=>
      (err_count == $past(err_count) + EW'(1))); // R4

  AST_HEAL_STEPS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (heal_tick && err_count != '0) |=>
      (err_count == $past(err_count) - EW'(1))); // R5

endmodule

bind lane_sync_fsm lane_sync_fsm_chk #(
  .ACQ_COMMAS (ACQ_COMMAS),
  .LOSS_ERRS  (LOSS_ERRS),
  .HEAL_RUN   (HEAL_RUN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cg_valid  (cg_valid),
  .cg_error  (cg_error),
  .sync_ok   (sync_ok),
  .err_count (err_count),
  .acq_done  (acq_done),
  .loss_hit  (loss_hit),
  .heal_tick (heal_tick)
);

// File: tb/lane_sync_fsm_test.sv
`timescale 1ns/1ps
module lane_sync_fsm_test;

  localparam int ACQ  = 4;
  localparam int LOSS = 17;
  localparam int HEAL = 16;
  localparam int EW   = $clog2(LOSS + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cg_valid = 1'b0;
  logic cg_comma = 1'b0;
  logic cg_error = 1'b0;
  logic sync_ok;
  logic [EW-1:0] err_count;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  lane_sync_fsm #(.ACQ_COMMAS(ACQ), .LOSS_ERRS(LOSS), .HEAL_RUN(HEAL)) uut (
    .clk(clk), .rst_n(rst_n), .cg_valid(cg_valid), .cg_comma(cg_comma),
    .cg_error(cg_error), .sync_ok(sync_ok), .err_count(err_count)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Present one cycle of inputs, return just after the capturing edge.
  task automatic cg(input logic v, input logic c, input logic e);
    @(negedge clk);
    cg_valid = v; cg_comma = c; cg_error = e;
    @(posedge clk);
    #1;
  endtask

  task automatic cg_n(input int n, input logic v, input logic c, input logic e);
    for (int i = 0; i < n; i++) cg(v, c, e);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cg_valid = 1'b0; cg_comma = 1'b0; cg_error = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic get_lock();
    do_reset();
    cg_n(ACQ, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    check("R1 sync after reset", sync_ok, 0);
    check("R1 tally after reset", err_count, 0);
  endtask

  task automatic t_acquire();
    do_reset();
    cg_n(ACQ - 1, 1'b1, 1'b1, 1'b0);
    check("R2 short of comma target", sync_ok, 0);
    cg_n(5, 1'b1, 1'b0, 1'b0);
    check("R2 plain good groups keep count", sync_ok, 0);
    cg(1'b1, 1'b1, 1'b0);
    check("R2 lock after last comma", sync_ok, 1);
    check("R2 tally zero at lock", err_count, 0);
  endtask

  task automatic t_acq_error();
    do_reset();
    cg_n(ACQ - 1, 1'b1, 1'b1, 1'b0);
    cg(1'b1, 1'b1, 1'b1);
    cg_n(ACQ - 1, 1'b1, 1'b1, 1'b0);
    check("R3 error restarts comma count", sync_ok, 0);
    cg(1'b1, 1'b1, 1'b0);
    check("R3 lock after fresh commas", sync_ok, 1);
  endtask

  task automatic t_idle();
    do_reset();
    cg_n(ACQ + 2, 1'b0, 1'b1, 1'b0);
    check("R7 idle commas do not lock", sync_ok, 0);
    cg_n(ACQ - 1, 1'b1, 1'b1, 1'b0);
    check("R7 idle commas not counted", sync_ok, 0);
    cg(1'b1, 1'b1, 1'b0);
    cg_n(2, 1'b1, 1'b0, 1'b1);
    check("R4 two errors", err_count, 2);
    cg_n(LOSS + 3, 1'b0, 1'b0, 1'b1);
    check("R7 idle errors ignored tally", err_count, 2);
    check("R7 idle errors keep lock", sync_ok, 1);
    cg_n(HEAL - 1, 1'b1, 1'b0, 1'b0);
    cg_n(5, 1'b0, 1'b0, 1'b1);
    cg(1'b1, 1'b0, 1'b0);
    check("R7 idle keeps good run", err_count, 1);
  endtask

  task automatic t_leak();
    get_lock();
    cg_n(3, 1'b1, 1'b0, 1'b1);
    check("R4 three errors", err_count, 3);
    cg_n(HEAL - 1, 1'b1, 1'b0, 1'b0);
    check("R5 short run no credit", err_count, 3);
    cg(1'b1, 1'b0, 1'b1);
    check("R4 error adds one", err_count, 4);
    cg_n(HEAL - 1, 1'b1, 1'b1, 1'b0);
    check("R4 run restarted by error", err_count, 4);
    cg(1'b1, 1'b0, 1'b0);
    check("R5 full run takes one", err_count, 3);
    get_lock();
    cg_n(2 * HEAL, 1'b1, 1'b0, 1'b0);
    check("R5 floor at zero", err_count, 0);
    cg(1'b1, 1'b0, 1'b1);
    check("R5 count after floor", err_count, 1);
  endtask

  task automatic t_loss();
    get_lock();
    cg_n(LOSS - 1, 1'b1, 1'b0, 1'b1);
    check("R6 below limit keeps lock", sync_ok, 1);
    check("R6 tally below limit", err_count, LOSS - 1);
    cg(1'b1, 1'b0, 1'b1);
    check("R6 lock dropped", sync_ok, 0);
    check("R6 tally cleared", err_count, 0);
    cg_n(ACQ - 1, 1'b1, 1'b1, 1'b0);
    check("R6 needs full reacquire", sync_ok, 0);
    cg(1'b1, 1'b1, 1'b0);
    check("R6 relocked", sync_ok, 1);
  endtask

  initial begin
    t_reset();
    t_acquire();
    t_acq_error();
    t_idle();
    t_leak();
    t_loss();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule